// File: doc/BRIEF.md
# Destination Address Filter Table

This block sits on the receive path of an Ethernet MAC and decides whether an incoming frame is kept or dropped, based only on its 48-bit destination address. The receive logic hands it the destination bytes one at a time, in wire order, and marks the first byte with a frame-start strobe. One cycle after the sixth byte, the block pulses a decision that gives accept or reject. It also reports whether a table entry matched and the index of that entry.

The table holds a parameterised number of station addresses, 16 by default. Entry 0 is meant for the device's own address. Each entry is written through two 32-bit configuration words and joins the comparison only while its bit in an enable mask is set. A control word holds three switches. The first turns address comparison on; while it is off, the block passes every frame. The other two admit all broadcast frames and all multicast frames, whatever the table holds.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_vld`, `dec_accept`, `dec_hit` and `dec_idx` are 0, every entry is disabled and all three control switches are clear.
- R2: When the sixth destination byte of a frame is taken (`rx_byte_vld` high at a clock edge), `dec_vld` is high for exactly the following cycle. Bytes after the sixth byte produce no further decision until the next frame start.
- R3: Writing configuration word 2*i (i below the entry count) loads the leading four address bytes of entry i: byte 0 from bits 31:24, byte 1 from 23:16, byte 2 from 15:8 and byte 3 from 7:0. Byte 0 is the first byte received.
- R4: Writing configuration word 2*i+1 loads byte 4 of entry i from bits 31:24 and byte 5 from bits 23:16. Bits 15:0 of that word have no effect on matching.
- R5: Configuration word 2*N is the enable mask, with bit i enabling entry i. A disabled entry never matches, even when its address equals the destination.
- R6: When several enabled entries match, `dec_idx` gives the lowest matching index and `dec_hit` is 1. When no enabled entry matches, `dec_hit` is 0 and `dec_idx` is 0.
- R7: Configuration word 2*N+1 is the control word: bit 0 enables comparison, bit 1 admits multicast and bit 2 admits broadcast. With bit 0 clear, every frame is accepted (promiscuous mode). With bit 0 set, a frame is accepted only if an enabled entry matches or one of the admit switches applies.
- R8: A destination of all ones (broadcast) is accepted when the broadcast switch is set. Broadcast is not treated as multicast, so the multicast switch alone does not admit it.
- R9: A destination whose byte 0 has bit 0 set, and which is not all ones, is multicast. It is accepted when the multicast switch is set.
- R10: `rx_sof` together with `rx_byte_vld` starts a new header at byte 0, even in the middle of a header. Bytes that arrive before any frame start are ignored.
- R11: While `dec_vld` is low, `dec_accept`, `dec_hit` and `dec_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word index (entries, then mask, then control) |
| cfg_wdata | input | 32 | Configuration write data |
| rx_sof | input | 1 | Marks the byte in `rx_byte` as destination byte 0 |
| rx_byte_vld | input | 1 | `rx_byte` carries a valid byte this cycle |
| rx_byte | input | 8 | Received byte |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_hit | output | 1 | An enabled table entry matched |
| dec_idx | output | 4 | Index of the lowest matching entry |

## Verification
The hardest case to reach from the ports is a random destination that collides with a table entry. This also covers two enabled entries holding the same address, where the priority order decides, and near-miss addresses that differ from an entry in one bit. The stimulus draws most destinations from the table the bench last wrote. It flips single bits of those entries and reloads the table with deliberate duplicates between random reconfigurations. Directed cases cover a header restarted part-way through, and broadcast and multicast frames under each combination of the three switches.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = MAC_BYTES * 8;
    localparam int CFG_DW    = 32;

    // bit positions inside the control word
    localparam int CTL_CMP_BIT = 0;
    localparam int CTL_MC_BIT  = 1;
    localparam int CTL_BC_BIT  = 2;

    typedef struct packed {
        logic acc_bc;
        logic acc_mc;
        logic cmp_en;
    } daf_ctl_t;
endpackage

// File: rtl/daf_table.sv
module daf_table
    import daf_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int CFG_AW = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [CFG_DW-1:0]            cfg_wdata,
    output logic [N_ENT-1:0][MAC_W-1:0]  ent_addr,
    output logic [N_ENT-1:0]             ent_en,
    output daf_ctl_t                     ctl
);
    localparam int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam int REG_MASK = 2 * N_ENT;
    localparam int REG_CTL  = 2 * N_ENT + 1;

    typedef struct packed {
        logic [N_ENT-1:0][MAC_W-1:0] addr;
        logic [N_ENT-1:0]            en;
        daf_ctl_t                    ctl;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [IDX_W-1:0] wr_idx;

    assign wr_idx = cfg_addr[IDX_W:1];

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we) begin
            if (cfg_addr < CFG_AW'(REG_MASK)) begin
                if (cfg_addr[0] == 1'b0) begin
                    tbl_d.addr[wr_idx][MAC_W-1:16] = cfg_wdata;
                end else begin
                    tbl_d.addr[wr_idx][15:0] = cfg_wdata[31:16];
                end
            end else if (cfg_addr == CFG_AW'(REG_MASK)) begin
                tbl_d.en = cfg_wdata[N_ENT-1:0];
            end else if (cfg_addr == CFG_AW'(REG_CTL)) begin
                tbl_d.ctl.cmp_en = cfg_wdata[CTL_CMP_BIT];
                tbl_d.ctl.acc_mc = cfg_wdata[CTL_MC_BIT];
                tbl_d.ctl.acc_bc = cfg_wdata[CTL_BC_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign ent_addr = tbl_q.addr;
    assign ent_en   = tbl_q.en;
    assign ctl      = tbl_q.ctl;
endmodule

// File: rtl/daf_collect.sv
module daf_collect
    import daf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_sof,
    input  logic             rx_byte_vld,
    input  logic [7:0]       rx_byte,
    output logic [MAC_W-1:0] hdr_addr,
    output logic             hdr_done
);
    localparam int CNT_W  = $clog2(MAC_BYTES + 1);
    localparam int HOLD_W = MAC_W - 8;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HOLD_W-1:0] held;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d    = col_q;
        hdr_done = 1'b0;
        if (rx_byte_vld) begin
            if (rx_sof) begin
                col_d.cnt  = CNT_W'(1);
                col_d.held = {{(HOLD_W-8){1'b0}}, rx_byte};
                hdr_done   = (MAC_BYTES == 1);
            end else if (col_q.cnt != '0 && col_q.cnt < CNT_W'(MAC_BYTES)) begin
                col_d.cnt  = col_q.cnt + CNT_W'(1);
                col_d.held = {col_q.held[HOLD_W-9:0], rx_byte};
                hdr_done   = (col_q.cnt == CNT_W'(MAC_BYTES - 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign hdr_addr = {col_q.held, rx_byte};
endmodule

// File: rtl/daf_match.sv
module daf_match
    import daf_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int IDX_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [MAC_W-1:0]            hdr_addr,
    input  logic                        hdr_done,
    input  logic [N_ENT-1:0][MAC_W-1:0] ent_addr,
    input  logic [N_ENT-1:0]            ent_en,
    input  daf_ctl_t                    ctl,
    output logic                        dec_vld,
    output logic                        dec_accept,
    output logic                        dec_hit,
    output logic [IDX_W-1:0]            dec_idx
);
    typedef struct packed {
        logic             vld;
        logic             accept;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } dec_t;

    dec_t dec_d, dec_q;
    logic [N_ENT-1:0] hits;
    logic [IDX_W-1:0] first_idx;
    logic is_bc, is_mc, any_hit;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hits[g] = ent_en[g] && (ent_addr[g] == hdr_addr);
    end

    // lowest index wins: scan downward so the last write is the smallest
    always_comb begin
        first_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hits[i]) first_idx = IDX_W'(i);
        end
    end

    assign any_hit = |hits;
    assign is_bc   = &hdr_addr;
    assign is_mc   = hdr_addr[MAC_W-8] && !is_bc;

    always_comb begin
        dec_d = '0;
        if (hdr_done) begin
            dec_d.vld    = 1'b1;
            dec_d.hit    = any_hit;
            dec_d.idx    = any_hit ? first_idx : '0;
            dec_d.accept = !ctl.cmp_en || any_hit ||
                           (is_bc && ctl.acc_bc) || (is_mc && ctl.acc_mc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_vld    = dec_q.vld;
    assign dec_accept = dec_q.accept;
    assign dec_hit    = dec_q.hit;
    assign dec_idx    = dec_q.idx;
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    parameter int CFG_AW = $clog2(2 * N_ENT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              rx_sof,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    output logic              dec_vld,
    output logic              dec_accept,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_idx
);
    logic [N_ENT-1:0][MAC_W-1:0] ent_addr;
    logic [N_ENT-1:0]            ent_en;
    daf_ctl_t                    ctl;
    logic [MAC_W-1:0]            hdr_addr;
    logic                        hdr_done;

    daf_table #(.N_ENT(N_ENT), .CFG_AW(CFG_AW)) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ent_addr(ent_addr), .ent_en(ent_en), .ctl(ctl)
    );

    daf_collect u_collect (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .hdr_addr(hdr_addr), .hdr_done(hdr_done)
    );

    daf_match #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst_n(rst_n), .hdr_addr(hdr_addr), .hdr_done(hdr_done),
        .ent_addr(ent_addr), .ent_en(ent_en), .ctl(ctl),
        .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_hit(dec_hit),
        .dec_idx(dec_idx)
    );
endmodule

// File: rtl/daf_chk.sv
module daf_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_byte_vld,
    input logic             cmp_en,
    input logic             dec_vld,
    input logic             dec_accept,
    input logic             dec_hit,
    input logic [IDX_W-1:0] dec_idx
);
    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

    // R2
    byte_before_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(rx_byte_vld));

    // R11
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> (!dec_accept && !dec_hit && dec_idx == '0));

    // R6
    miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !dec_hit) |-> dec_idx == '0);

    // R7
    hit_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_hit) |-> dec_accept);

    // R7
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !$past(cmp_en)) |-> dec_accept);
endmodule

bind dst_addr_filter daf_chk #(.IDX_W(IDX_W)) u_daf_chk (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .cmp_en(ctl.cmp_en),
    .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_hit(dec_hit),
    .dec_idx(dec_idx)
);

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_sof = 1'b0;
    logic        rx_byte_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_vld, dec_accept, dec_hit;
    logic [3:0]  dec_idx;

    int total = 0;
    int bad = 0;

    logic [47:0] m_addr [N];
    logic [N-1:0] m_en = '0;
    logic m_cmp = 0, m_mc = 0, m_bc = 0;

    always #4 clk = ~clk;

    dst_addr_filter i_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .dec_vld(dec_vld), .dec_accept(dec_accept),
        .dec_hit(dec_hit), .dec_idx(dec_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 6'(2 * N)) begin
            if (a[0] == 1'b0) m_addr[a[4:1]][47:16] = d;
            else              m_addr[a[4:1]][15:0]  = d[31:16];
        end else if (a == 6'(2 * N)) begin
            m_en = d[N-1:0];
        end else if (a == 6'(2 * N + 1)) begin
            m_cmp = d[0]; m_mc = d[1]; m_bc = d[2];
        end
    endtask

    task automatic load_entry(input int i, input logic [47:0] a, input logic [15:0] junk);
        wr(6'(2 * i), a[47:16]);
        wr(6'(2 * i + 1), {a[15:0], junk});
    endtask

    function automatic logic [5:0] expect_dec(input logic [47:0] a);
        logic hit = 1'b0;
        logic [3:0] idx = '0;
        logic bc, mc, acc;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_en[i] && m_addr[i] == a) begin hit = 1'b1; idx = 4'(i); end
        end
        bc  = (a == 48'hFFFF_FFFF_FFFF);
        mc  = a[40] && !bc;
        acc = !m_cmp || hit || (bc && m_bc) || (mc && m_mc);
        return {acc, hit, idx};
    endfunction

    task automatic check_dec(input string req, input logic [47:0] a);
        logic [5:0] e;
        e = expect_dec(a);
        chk({req, " vld"}, 32'(dec_vld), 32'd1);
        chk({req, " dec"}, {26'd0, dec_accept, dec_hit, dec_idx}, 32'(e));
    endtask

    // six header bytes, decision check, then trailing bytes (R2)
    task automatic send_hdr(input string req, input logic [47:0] a);
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            rx_byte_vld = 1'b1; rx_sof = (b == 0); rx_byte = a[47-8*b -: 8];
        end
        @(negedge clk);
        rx_byte_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'hA5;
        check_dec(req, a);
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            rx_byte_vld = (t == 0); rx_byte = 8'h3C;
            chk("R2 no second decision", 32'(dec_vld), 32'd0);
        end
    endtask

    function automatic logic [47:0] rnd48();
        return {16'($urandom), $urandom};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) m_addr[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset dec_vld", 32'(dec_vld), 0);
        chk("R1 reset outputs", {29'd0, dec_accept, dec_hit, dec_idx == 4'd0}, 32'd1);
        rst_n = 1'b1;

        // R1/R7: cleared config is promiscuous, nothing enabled
        send_hdr("R7 reset promiscuous", 48'h0012_3456_789A);

        // R10: bytes without any frame start are ignored
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            rx_byte_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'(b);
            chk("R10 no sof ignored", 32'(dec_vld), 0);
        end
        @(negedge clk); rx_byte_vld = 1'b0;
        chk("R10 no sof ignored", 32'(dec_vld), 0);

        // R3/R4: field layout and ignored low bits
        load_entry(0, 48'h0211_2233_4455, 16'hABCD);
        wr(6'(2 * N), 32'h0000_0001);
        wr(6'(2 * N + 1), 32'h1);
        send_hdr("R3 R4 entry0 match", 48'h0211_2233_4455);
        send_hdr("R4 byte5 differs", 48'h0211_2233_4456);
        send_hdr("R3 byte0 differs", 48'h0611_2233_4455);
        wr(6'd1, 32'h4455_0000);
        send_hdr("R4 low bits no effect", 48'h0211_2233_4455);

        // R5/R6: priority and enable
        load_entry(3, 48'h00AA_BBCC_DDEE, 16'h0);
        load_entry(5, 48'h00AA_BBCC_DDEE, 16'h1);
        wr(6'(2 * N), 32'h0000_0029);
        send_hdr("R6 lowest index", 48'h00AA_BBCC_DDEE);
        wr(6'(2 * N), 32'h0000_0021);
        send_hdr("R5 disabled skipped", 48'h00AA_BBCC_DDEE);
        wr(6'(2 * N), 32'h0000_0001);
        send_hdr("R5 all disabled", 48'h00AA_BBCC_DDEE);

        // R8/R9: broadcast and multicast switches
        send_hdr("R8 bc rejected", 48'hFFFF_FFFF_FFFF);
        wr(6'(2 * N + 1), 32'h3);
        send_hdr("R8 bc not multicast", 48'hFFFF_FFFF_FFFF);
        send_hdr("R9 mc accepted", 48'h0100_5E00_0001);
        wr(6'(2 * N + 1), 32'h5);
        send_hdr("R8 bc accepted", 48'hFFFF_FFFF_FFFF);
        send_hdr("R9 mc rejected", 48'h0100_5E00_0001);

        // R10: restart in the middle of a header
        for (int b = 0; b < 3; b++) begin
            @(negedge clk);
            rx_byte_vld = 1'b1; rx_sof = (b == 0); rx_byte = 8'h77;
        end
        send_hdr("R10 restart mid header", 48'h0211_2233_4455);

        // R7: comparison off with a loaded table
        wr(6'(2 * N + 1), 32'h0);
        send_hdr("R7 promiscuous", 48'h0077_0000_1234);

        // random mix with a model table
        for (int f = 0; f < 400; f++) begin
            logic [47:0] a;
            int k;
            if (f % 40 == 0) begin
                for (int i = 0; i < 4; i++) begin
                    int e = $urandom % N;
                    if ($urandom % 3 == 0) load_entry(e, m_addr[$urandom % N], 16'($urandom));
                    else load_entry(e, rnd48(), 16'($urandom));
                end
                wr(6'(2 * N), $urandom);
                wr(6'(2 * N + 1), $urandom % 8);
            end
            k = $urandom % N;
            case ($urandom % 5)
                0: a = m_addr[k];
                1: a = 48'hFFFF_FFFF_FFFF;
                2: a = rnd48() | 48'h0100_0000_0000;
                3: a = rnd48() & ~48'h0100_0000_0000;
                default: a = m_addr[k] ^ (48'd1 << ($urandom % 48));
            endcase
            send_hdr("R6 R7 R8 R9 random", a);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule